// File: doc/BRIEF.md
# Indexed Pixel Expander

This block sits between a frame-data fetch engine and a display pipeline. It accepts 32-bit words over a valid/ready handshake and converts them into a stream of 16-bit RGB565 pixels, also under valid/ready. For low colour depths (1, 2, 4 or 8 bits per pixel) each packed field is an index into an internal 16-bit palette. For 16-bit and 15-bit depths each halfword is passed through unchanged. In the 15-bit case a side flag marks the pixel as RGB555.

The palette is filled in-band. Words that arrive with the palette flag set are written into the palette, two entries per word, and produce no pixels. Words with the flag clear are frame data. A run of palette words always fills the table from entry 0 upward. The depth setting is captured together with each data word, so the setting may change freely between words.

Top module: `idx_pixel_expander`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and every palette entry reads 0.
- R2: px_mode encodes the depth: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp (all indexed); 4 = 16 bpp pass-through; 5 = 15 bpp pass-through with out_rgb555 = 1; 6 and 7 act as 4. out_rgb555 is 0 for every other mode.
- R3: A data word yields 32/bpp pixels (2 in pass-through modes), taken from bit 0 upward.
- R4: In indexed modes out_pix equals the palette entry selected by the pixel field.
- R5: In pass-through modes out_pix equals the halfword, lower halfword first.
- R6: A word accepted with in_pal = 1 writes two palette entries, with bits 15:0 at the lower index and bits 31:16 at the next index. It produces no pixel.
- R7: The first palette word after reset, or after a data word, writes entries 0 and 1. Each following palette word in the same run writes the next two entries, and the write position wraps at the palette depth.
- R8: While out_valid = 1 and out_ready = 0, out_pix and out_rgb555 hold.
- R9: in_ready is 0 while a data word still has pixels to emit. The exception is the cycle in which its last pixel is taken: in that cycle in_ready is 1 and a new word is accepted.
- R10: The depth is taken from px_mode when a data word is accepted. Later changes to px_mode do not affect that word.
- R11: A palette write accepted in the same cycle as a pixel handshake affects only pixels emitted in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Packed frame word or two palette entries |
| in_pal | input | 1 | Marks the word as palette data |
| px_mode | input | 3 | Depth code, sampled with each data word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pix | output | 16 | RGB565 (or RGB555) pixel |
| out_rgb555 | output | 1 | Pixel is in 15-bit format |

## Verification
Two functions can fall in the same cycle: a palette word can be accepted on the very edge where the last pixel of the previous data word is handed over. The bench provokes this in two ways. In a directed case, palette words that overwrite the entries the pending word uses queue right behind it while the output is always ready. The random mix of data words and short palette runs provokes it as well. The reference model compares each emitted pixel against the palette as it stood before that edge and applies the write afterwards. The bench also counts how often the overlap occurred and requires that it did.

// File: rtl/idx_pixel_expander.sv
module idx_pixel_expander #(
  parameter int PAL_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_pal,
  input  logic [2:0]  px_mode,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_pix,
  output logic        out_rgb555
);

  localparam int AW = $clog2(PAL_DEPTH);

  logic [15:0]   pal [PAL_DEPTH];
  logic [31:0]   word_q;
  logic [2:0]    mode_q;
  logic [4:0]    pos_q;
  logic          busy_q;
  logic          run_q;
  logic [AW-1:0] wptr_q;

  logic [2:0]    shf;
  logic [4:0]    last_pos;
  logic [8:0]    sh_amt;
  logic [15:0]   field;
  logic [7:0]    idx_raw;
  logic          indexed;
  logic          fire_out, done, take, take_pal, take_dat;
  logic [AW-1:0] base;

  assign indexed  = (mode_q < 3'd4);
  assign shf      = indexed ? mode_q : 3'd4;
  assign last_pos = 5'((32 >> shf) - 1);
  assign sh_amt   = 9'(pos_q) << shf;
  assign field    = 16'(word_q >> sh_amt);

  always_comb begin
    case (shf)
      3'd0:    idx_raw = {7'b0, field[0]};
      3'd1:    idx_raw = {6'b0, field[1:0]};
      3'd2:    idx_raw = {4'b0, field[3:0]};
      default: idx_raw = field[7:0];
    endcase
  end

  assign out_valid  = busy_q;
  assign out_pix    = indexed ? pal[AW'(idx_raw)] : field;
  assign out_rgb555 = busy_q && (mode_q == 3'd5);

  assign fire_out = busy_q && out_ready;
  assign done     = fire_out && (pos_q == last_pos);
  assign in_ready = !busy_q || done;
  assign take     = in_valid && in_ready;
  assign take_pal = take && in_pal;
  assign take_dat = take && !in_pal;
  assign base     = run_q ? wptr_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= '0;
      pos_q  <= '0;
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      wptr_q <= '0;
    end else begin
      if (take_dat) begin
        busy_q <= 1'b1;
        word_q <= in_data;
        mode_q <= px_mode;
        pos_q  <= '0;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (fire_out) begin
        pos_q <= pos_q + 5'd1;
      end
      if (take) run_q <= in_pal;
      if (take_pal) wptr_q <= base + AW'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_DEPTH; i++) pal[i] <= '0;
    end else if (take_pal) begin
      pal[{base[AW-1:1], 1'b0}] <= in_data[15:0];
      pal[{base[AW-1:1], 1'b1}] <= in_data[31:16];
    end
  end

endmodule

// File: rtl/idx_pixel_expander_chk.sv
module idx_pixel_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_pal,
  input logic [2:0]  px_mode,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_pix,
  input logic        out_rgb555
);

  // R8
  hold_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_rgb555));

  // R9
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6
  pal_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_pal && !out_valid |=> !out_valid);

  // R3
  dat_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_pal |=> out_valid);

  // R2
  rgb555_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_pal && px_mode == 3'd5 |=> out_rgb555);

  // R2
  rgb565_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_pal && px_mode != 3'd5 |=> !out_rgb555);

endmodule

bind idx_pixel_expander idx_pixel_expander_chk chk_i (.*);

// File: tb/idx_pixel_expander_test.sv
module idx_pixel_expander_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_pal = 1'b0;
  logic [2:0]  px_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_pix;
  logic        out_rgb555;

  idx_pixel_expander uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, overlap = 0, rdy_pct = 100;
  bit finished = 1'b0;
  logic [15:0] mpal [256];
  logic [31:0] qw [$];
  logic [2:0]  qm [$];
  int qi = 0;
  bit mrun = 1'b0;
  int mptr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ppw(input logic [2:0] m);
    return (m < 3'd4) ? (32 >> m) : 2;
  endfunction

  function automatic logic [15:0] exp_pix(input logic [31:0] w, input logic [2:0] m, input int i);
    int b;
    logic [31:0] f;
    b = (m < 3'd4) ? (1 << m) : 16;
    f = w >> (i * b);
    if (m < 3'd4) return mpal[int'(f) & ((1 << b) - 1)];
    return f[15:0];
  endfunction

  task automatic cycle(input bit have, input logic [31:0] w, input bit p, input logic [2:0] m, output bit took);
    bit eready;
    @(negedge clk);
    out_ready = ($urandom % 100) < rdy_pct;
    in_valid  = have;
    if (have) begin
      in_data = w; in_pal = p; px_mode = m;
    end else begin
      in_data = $urandom; in_pal = 1'($urandom); px_mode = 3'($urandom);
    end
    #1;
    eready = (qw.size() == 0) || (out_ready && qi == ppw(qm[0]) - 1);
    // R9 input stall
    chk(in_ready == eready, "R9", 32'(in_ready), 32'(eready));
    chk(out_valid == (qw.size() != 0), "R3/R6 out_valid", 32'(out_valid), 32'(qw.size() != 0));
    if (out_valid && qw.size() != 0) begin
      // R4 R5 R10 pixel value
      chk(out_pix == exp_pix(qw[0], qm[0], qi), "R4/R5/R10 pixel", 32'(out_pix), 32'(exp_pix(qw[0], qm[0], qi)));
      // R2
      chk(out_rgb555 == (qm[0] == 3'd5), "R2 rgb555", 32'(out_rgb555), 32'(qm[0] == 3'd5));
      if (out_ready) begin
        qi++;
        if (qi == ppw(qm[0])) begin
          qi = 0; void'(qw.pop_front()); void'(qm.pop_front());
        end
      end
    end
    took = have && in_ready;
    if (took && p && out_valid && out_ready) overlap++;
    if (took) begin
      if (p) begin
        int b;
        b = mrun ? mptr : 0;
        mpal[b] = w[15:0];
        mpal[b + 1] = w[31:16];
        mptr = (b + 2) % 256;
        mrun = 1'b1;
      end else begin
        mrun = 1'b0;
        qw.push_back(w); qm.push_back(m);
      end
    end
  endtask

  task automatic send(input logic [31:0] w, input bit p, input logic [2:0] m);
    bit took = 1'b0;
    while (!took) cycle(1'b1, w, p, m, took);
  endtask

  task automatic drain();
    bit t;
    int lim = 0;
    while (qw.size() != 0 && lim < 5000) begin cycle(1'b0, '0, 1'b0, '0, t); lim++; end
    cycle(1'b0, '0, 1'b0, '0, t);
  endtask

  initial begin
    void'($urandom(32'h5EED_0679));
    for (int i = 0; i < 256; i++) mpal[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
    rst_n = 1'b1;

    // R1 palette reads zero before any load
    rdy_pct = 100;
    send(32'hFF03_0201, 1'b0, 3'd3);
    send(32'h8421_F00F, 1'b0, 3'd2);
    drain();

    // R6 R7 full load of 256 entries plus two words that wrap to entry 0
    for (int i = 0; i < 130; i++) send($urandom, 1'b1, 3'd0);
    for (int i = 0; i < 8; i++) send({i[5:0], 2'd3, i[5:0], 2'd2, i[5:0], 2'd1, i[5:0], 2'd0}, 1'b0, 3'd3);
    drain();

    // R7 a new run restarts at entry 0
    send(32'hAAAA_5555, 1'b1, 3'd0);
    send(32'h0102_0304, 1'b0, 3'd0);
    drain();

    // R11 palette words queued right behind a data word that uses the same entries
    rdy_pct = 100;
    send(32'h1010_1010, 1'b0, 3'd2);
    send(32'hBEEF_CAFE, 1'b1, 3'd0);
    send(32'h1234_5678, 1'b1, 3'd0);
    send(32'h1010_1010, 1'b0, 3'd2);
    drain();

    // R2 R3 R5 R8 R10 random mix
    for (int ph = 0; ph < 3; ph++) begin
      rdy_pct = (ph == 0) ? 30 : (ph == 1) ? 70 : 100;
      for (int k = 0; k < 150; k++) begin
        if ($urandom % 100 < 15) begin
          int n;
          n = 1 + int'($urandom % 4);
          for (int j = 0; j < n; j++) send($urandom, 1'b1, 3'd0);
        end else begin
          send($urandom, 1'b0, 3'($urandom));
        end
        if ($urandom % 100 < 20) begin
          bit t;
          cycle(1'b0, '0, 1'b0, '0, t);
        end
      end
      drain();
    end

    // R11 overlap must have occurred
    chk(overlap > 0, "R11 overlap seen", 32'(overlap), 1);
    chk(qw.size() == 0, "R3 all pixels emitted", 32'(qw.size()), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule